// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two external-bus strobes of an 8051-class core: an address-latch pulse and an active-low code-fetch read strobe. A free-running tick counter splits each machine cycle into six states of two phases each, so one cycle is twelve oscillator clocks. It also reports the current state and phase. The strobes are decoded from that counter and from four per-cycle mode flags.

The flags come from the core. One says code is being fetched from external memory. One marks the data cycle of an external data move. One marks a code-table read. One is the software bit that quietens the address-latch pulse. The block captures the flags at the clock edge that closes a machine cycle, and they hold for the whole of the next cycle.

During a flagged external data cycle, the first address-latch pulse of the cycle is dropped. Both code-fetch strobes that would start in that cycle are also dropped. The quiet bit stops the address-latch pulse, except in cycles flagged as data moves or code-table reads. It has no effect while code runs from external memory. All pins are plain control and status lines: there is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_strobe_gen`

## Requirements
- R1: While reset is high, the tick is S1P1 (`state_o`=0, `phase_o`=0), `ale_o` is 0 and `psen_n_o` is 1. Reset clears all captured mode flags. The first machine cycle after reset therefore runs with internal execution and the address-latch pulse enabled, whatever the inputs are.
- R2: The tick advances by one every clock and wraps after twelve clocks. `state_o` = tick/2 (0 means S1, 5 means S6) and `phase_o` = tick mod 2 (0 means P1, 1 means P2).
- R3: With the pulse enabled and no data cycle flagged, `ale_o` is 1 for exactly one clock, at tick 1 (S1P2) and at tick 7 (S4P2). That gives two pulses per machine cycle.
- R4: In a cycle flagged by `movx_i`, the tick-1 address-latch pulse is omitted and the tick-7 pulse is kept.
- R5: With `ale_quiet_i` captured as 1 and external execution off, `ale_o` stays 0 for the whole cycle. The exception is a cycle flagged by `movx_i` (tick-7 pulse only) or by `movc_i` (both pulses).
- R6: With external execution captured as 1, `ale_quiet_i` has no effect, and the address-latch pulses follow R3/R4.
- R7: With external execution on and no data cycle flagged, `psen_n_o` is 0 for ticks 4 to 7 (S3–S4). It is also 0 for ticks 10 and 11 (S6), continuing through ticks 0 and 1 (S1) of the following cycle. That gives two falling edges per cycle.
- R8: In an external-execution cycle flagged by `movx_i`, the strobes that would fall at ticks 4 and 10 are skipped, and ticks 0 and 1 of the next cycle stay high. The tail at ticks 0 and 1 of the flagged cycle itself, left over from the cycle before, is still driven low.
- R9: With external execution off, and no tail left over from an external cycle, `psen_n_o` stays 1.
- R10: The mode inputs are captured only at the edge that ends tick 11. A change that is applied and removed within one cycle has no effect on any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ext_exec_i | input | 1 | Code is executing from external program memory |
| movx_i | input | 1 | Marks the data cycle of an external data move |
| movc_i | input | 1 | Marks a code-table read cycle |
| ale_quiet_i | input | 1 | Software bit that quietens the address-latch pulse |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Code-fetch read strobe, active low |
| state_o | output | 3 | Current state, 0..5 for S1..S6 |
| phase_o | output | 1 | Current phase, 0 for P1, 1 for P2 |

## Verification
Every output is decoded from flops only, so each strobe and the state/phase value change in the same clock as the tick register. There is no extra pipeline delay. A mode change takes effect from tick 0 of the machine cycle that follows the closing edge of tick 11, so a flag moved mid-cycle shows up between one and twelve clocks later. The bench's reference model advances on each rising edge using the inputs held at that edge, and all comparisons are made on the falling edge that follows. Inputs are changed only on falling edges at chosen ticks, and edge counts are gathered over whole machine cycles, from tick 0 to tick 11.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  // Per-machine-cycle mode captured at the cycle boundary.
  typedef struct packed {
    logic ext_exec;   // fetching code from external memory
    logic data_move;  // this is the data cycle of an external data move
    logic code_read;  // code-table read in progress
    logic ale_quiet;  // software request to quieten the latch pulse
  } cycle_mode_t;

  localparam cycle_mode_t MODE_RESET = '{ext_exec: 1'b0, data_move: 1'b0,
                                         code_read: 1'b0, ale_quiet: 1'b0};

endpackage

// File: rtl/sg_tick_counter.sv
module sg_tick_counter #(
  parameter int STATES = 6,
  parameter int PHASES = 2
) (
  input  logic                                        clk_i,
  input  logic                                        rst_i,
  output logic [$clog2(STATES*PHASES)-1:0]            tick_o,
  output logic                                        last_o,
  output logic [$clog2(STATES)-1:0]                   state_o,
  output logic [((PHASES > 1) ? $clog2(PHASES) : 1)-1:0] phase_o
);
  localparam int TICKS = STATES * PHASES;
  localparam int TW    = $clog2(TICKS);
  localparam int SW    = $clog2(STATES);
  localparam int PW    = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [TW-1:0] LAST_T  = TW'(TICKS - 1);
  localparam logic [TW-1:0] PHASE_T = TW'(PHASES);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)              tick_q <= '0;
    else if (tick_q == LAST_T) tick_q <= '0;
    else                    tick_q <= tick_q + 1'b1;
  end

  assign tick_o  = tick_q;
  assign last_o  = (tick_q == LAST_T);
  assign state_o = SW'(tick_q / PHASE_T);
  assign phase_o = PW'(tick_q % PHASE_T);

  // R2: the counter wraps to S1P1 after the last phase
  assert_tick_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    last_o |=> (tick_q == '0));

  // R2: otherwise it steps by exactly one
  assert_tick_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !last_o |=> (tick_q == $past(tick_q) + 1'b1));

endmodule

// File: rtl/sg_mode_latch.sv
module sg_mode_latch
  import bus_strobe_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        load_i,
  input  logic        ext_exec_i,
  input  logic        movx_i,
  input  logic        movc_i,
  input  logic        ale_quiet_i,
  output cycle_mode_t mode_o
);
  cycle_mode_t mode_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= MODE_RESET;
    end else if (load_i) begin
      mode_q.ext_exec  <= ext_exec_i;
      mode_q.data_move <= movx_i;
      mode_q.code_read <= movc_i;
      mode_q.ale_quiet <= ale_quiet_i;
    end
  end

  assign mode_o = mode_q;

  // R10: mode only moves at the cycle boundary
  assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> $stable(mode_q));

endmodule

// File: rtl/sg_strobe_decode.sv
module sg_strobe_decode
  import bus_strobe_pkg::*;
#(
  parameter int STATES       = 6,
  parameter int PHASES       = 2,
  parameter int ALE_STATE_A  = 0,
  parameter int ALE_STATE_B  = 3,
  parameter int ALE_SKIP     = 0,
  parameter int PSEN_STATE_A = 2,
  parameter int PSEN_STATE_B = 5,
  parameter int PSEN_STATES  = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_i,
  input  logic [$clog2(STATES*PHASES)-1:0]  tick_i,
  input  logic                              last_i,
  input  cycle_mode_t                       mode_i,
  output logic                              ale_o,
  output logic                              psen_n_o
);
  localparam int TICKS = STATES * PHASES;
  localparam int TW    = $clog2(TICKS);

  logic [TW:0] tick_x;
  assign tick_x = {1'b0, tick_i};

  // ---------------- address-latch pulses ----------------
  logic [1:0] ale_hit;
  logic       ale_enable;

  for (genvar g = 0; g < 2; g++) begin : g_ale_slot
    localparam int ST = (g == 0) ? ALE_STATE_A : ALE_STATE_B;
    localparam logic [TW:0] SLOT_T = (TW+1)'(ST * PHASES + PHASES - 1);
    localparam bit SKIPPABLE = (g == ALE_SKIP);
    assign ale_hit[g] = (tick_x == SLOT_T) && !(SKIPPABLE && mode_i.data_move);
  end

  assign ale_enable = mode_i.ext_exec | ~mode_i.ale_quiet |
                      mode_i.data_move | mode_i.code_read;
  assign ale_o = ale_enable & (|ale_hit);

  // ---------------- code-fetch strobes ----------------
  logic       fetch_issue;
  logic [1:0] win_hit;
  logic [1:0] tail_hit;

  assign fetch_issue = mode_i.ext_exec & ~mode_i.data_move;

  for (genvar g = 0; g < 2; g++) begin : g_psen_win
    localparam int ST    = (g == 0) ? PSEN_STATE_A : PSEN_STATE_B;
    localparam int LO    = ST * PHASES;
    localparam int HI_X  = LO + PSEN_STATES * PHASES;
    localparam int IN_HI = (HI_X > TICKS) ? TICKS : HI_X;
    localparam int TAIL  = (HI_X > TICKS) ? (HI_X - TICKS) : 0;
    localparam logic [TW:0] LO_T = (TW+1)'(LO);
    localparam logic [TW:0] HI_T = (TW+1)'(IN_HI);

    assign win_hit[g] = fetch_issue && (tick_x >= LO_T) && (tick_x < HI_T);

    if (TAIL > 0) begin : g_tail
      localparam logic [TW:0] TAIL_T = (TW+1)'(TAIL);
      logic tail_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)       tail_q <= 1'b0;
        else if (last_i) tail_q <= fetch_issue;
      end
      assign tail_hit[g] = tail_q && (tick_x < TAIL_T);
    end else begin : g_no_tail
      assign tail_hit[g] = 1'b0;
    end
  end

  assign psen_n_o = ~((|win_hit) | (|tail_hit));

  // R3: each latch pulse is a single clock wide
  assert_ale_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    ale_o |=> !ale_o);

  // R4: the skippable slot stays quiet in a data-move cycle
  assert_ale_skip_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i.data_move && tick_x == (TW+1)'(ALE_STATE_A * PHASES + PHASES - 1))
      |-> !ale_o);

  // R7: a fetch strobe, once started, lasts at least one more clock
  assert_psen_width_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(psen_n_o) |=> !psen_n_o);

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int STATES       = 6,
  parameter int PHASES       = 2,
  parameter int ALE_STATE_A  = 0,
  parameter int ALE_STATE_B  = 3,
  parameter int ALE_SKIP     = 0,
  parameter int PSEN_STATE_A = 2,
  parameter int PSEN_STATE_B = 5,
  parameter int PSEN_STATES  = 2
) (
  input  logic                                           clk_i,
  input  logic                                           rst_i,
  input  logic                                           ext_exec_i,
  input  logic                                           movx_i,
  input  logic                                           movc_i,
  input  logic                                           ale_quiet_i,
  output logic                                           ale_o,
  output logic                                           psen_n_o,
  output logic [$clog2(STATES)-1:0]                      state_o,
  output logic [((PHASES > 1) ? $clog2(PHASES) : 1)-1:0] phase_o
);
  localparam int TW = $clog2(STATES * PHASES);

  logic [TW-1:0] tick;
  logic          last;
  cycle_mode_t   mode;

  sg_tick_counter #(.STATES(STATES), .PHASES(PHASES)) u_tick (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_o  (tick),
    .last_o  (last),
    .state_o (state_o),
    .phase_o (phase_o)
  );

  sg_mode_latch u_mode (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .load_i      (last),
    .ext_exec_i  (ext_exec_i),
    .movx_i      (movx_i),
    .movc_i      (movc_i),
    .ale_quiet_i (ale_quiet_i),
    .mode_o      (mode)
  );

  sg_strobe_decode #(
    .STATES       (STATES),
    .PHASES       (PHASES),
    .ALE_STATE_A  (ALE_STATE_A),
    .ALE_STATE_B  (ALE_STATE_B),
    .ALE_SKIP     (ALE_SKIP),
    .PSEN_STATE_A (PSEN_STATE_A),
    .PSEN_STATE_B (PSEN_STATE_B),
    .PSEN_STATES  (PSEN_STATES)
  ) u_decode (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_i   (tick),
    .last_i   (last),
    .mode_i   (mode),
    .ale_o    (ale_o),
    .psen_n_o (psen_n_o)
  );

endmodule

// File: tb/bus_strobe_gen_test.sv
`timescale 1ns/1ps
module bus_strobe_gen_test;
  logic clk = 1'b0;
  logic rst_i = 1'b1, ext_i = 1'b0, movx_i = 1'b0, movc_i = 1'b0, quiet_i = 1'b0;
  logic ale_o, psen_n_o, phase_o;
  logic [2:0] state_o;

  always #2.5 clk = ~clk;  // 200 MHz

  bus_strobe_gen uut (
    .clk_i(clk), .rst_i(rst_i), .ext_exec_i(ext_i), .movx_i(movx_i),
    .movc_i(movc_i), .ale_quiet_i(quiet_i), .ale_o(ale_o),
    .psen_n_o(psen_n_o), .state_o(state_o), .phase_o(phase_o)
  );

  int n_cmp = 0, n_bad = 0;

  // Behavioural reference: tick and the mode captured at each boundary
  int m_t = 0;
  bit m_ext, m_movx, m_movc, m_quiet, m_tail;

  always @(posedge clk) begin
    if (rst_i) begin
      m_t = 0; m_ext = 0; m_movx = 0; m_movc = 0; m_quiet = 0; m_tail = 0;
    end else if (m_t == 11) begin
      m_tail = m_ext && !m_movx;
      m_ext = ext_i; m_movx = movx_i; m_movc = movc_i; m_quiet = quiet_i;
      m_t = 0;
    end else begin
      m_t++;
    end
  end

  function automatic bit exp_ale();
    bit en = m_ext || !m_quiet || m_movx || m_movc;
    return en && ((m_t == 1 && !m_movx) || m_t == 7);
  endfunction

  function automatic bit exp_psen_n();
    bit low = (m_ext && !m_movx && ((m_t >= 4 && m_t <= 7) || m_t >= 10)) ||
              (m_tail && m_t <= 1);
    return !low;
  endfunction

  function automatic string ale_tag();
    if (m_movx) return "R4";
    if (m_quiet && m_ext) return "R6";
    if (m_quiet) return "R5";
    return "R3";
  endfunction

  function automatic string psen_tag();
    if ((m_tail && m_t < 2) || (m_ext && m_movx)) return "R8";
    if (!m_ext) return "R9";
    return "R7";
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-clock comparison, half a period after each rising edge
  always @(negedge clk) begin
    if (!rst_i) begin
      chk(state_o == 3'(m_t / 2), "R2", "state", int'(state_o), m_t / 2);
      chk(phase_o == 1'(m_t % 2), "R2", "phase", int'(phase_o), m_t % 2);
      chk(ale_o == exp_ale(), ale_tag(), "ale", int'(ale_o), int'(exp_ale()));
      chk(psen_n_o == exp_psen_n(), psen_tag(), "psen_n", int'(psen_n_o),
          int'(exp_psen_n()));
    end
  end

  task automatic step_to(int t);
    @(negedge clk);
    while (m_t != t) @(negedge clk);
  endtask

  task automatic count_cycles(int n, output int ale_rise, output int psen_fall);
    bit pa = ale_o, pp = psen_n_o;
    ale_rise = 0; psen_fall = 0;
    for (int i = 0; i < n * 12; i++) begin
      @(negedge clk);
      if (ale_o && !pa) ale_rise++;
      if (!psen_n_o && pp) psen_fall++;
      pa = ale_o; pp = psen_n_o;
    end
  endtask

  // Inputs moved mid-cycle; counts taken over whole cycles once captured
  task automatic run_mode(bit e, bit x, bit c, bit q, int exp_a, int exp_p,
                          string tag_a, string tag_p);
    int a, p;
    step_to(5);
    ext_i = e; movx_i = x; movc_i = c; quiet_i = q;
    step_to(11);
    count_cycles(3, a, p);
    chk(a == exp_a * 3, tag_a, "ale pulse count", a, exp_a * 3);
    chk(p == exp_p * 3, tag_p, "psen strobe count", p, exp_p * 3);
  endtask

  initial begin
    int a, p;
    quiet_i = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(ale_o == 1'b0, "R1", "ale in reset", int'(ale_o), 0);
    chk(psen_n_o == 1'b1, "R1", "psen_n in reset", int'(psen_n_o), 1);
    chk(state_o == 3'd0 && phase_o == 1'b0, "R1", "tick in reset",
        int'({state_o, phase_o}), 0);
    rst_i = 1'b0;
    @(negedge clk);
    // R1: quiet bit not yet captured, so the S1P2 pulse appears
    chk(ale_o == 1'b1, "R1", "first S1P2 ale", int'(ale_o), 1);

    run_mode(0, 0, 0, 0, 2, 0, "R3", "R9");
    run_mode(0, 1, 0, 0, 1, 0, "R4", "R9");
    run_mode(0, 0, 0, 1, 0, 0, "R5", "R9");
    run_mode(0, 0, 1, 1, 2, 0, "R5", "R9");
    run_mode(0, 1, 0, 1, 1, 0, "R5", "R9");
    run_mode(1, 0, 0, 0, 2, 2, "R3", "R7");
    run_mode(1, 0, 0, 1, 2, 2, "R6", "R7");
    run_mode(1, 1, 0, 0, 1, 0, "R4", "R8");

    // R8: single flagged data cycle between external fetch cycles
    run_mode(1, 0, 0, 0, 2, 2, "R3", "R7");
    step_to(5); movx_i = 1'b1;
    step_to(0);
    chk(psen_n_o == 1'b0, "R8", "tail kept in flagged cycle", int'(psen_n_o), 0);
    step_to(4);
    chk(psen_n_o == 1'b1, "R8", "S3 strobe skipped", int'(psen_n_o), 1);
    step_to(5); movx_i = 1'b0;
    step_to(0);
    chk(psen_n_o == 1'b1, "R8", "tail dropped after flagged cycle", int'(psen_n_o), 1);
    step_to(4);
    chk(psen_n_o == 1'b0, "R7", "strobe resumes", int'(psen_n_o), 0);

    // R10: flags pulsed inside one cycle and removed before its end
    run_mode(0, 0, 0, 0, 2, 0, "R3", "R9");
    step_to(3); movx_i = 1'b1; quiet_i = 1'b1; ext_i = 1'b1;
    step_to(8); movx_i = 1'b0; quiet_i = 1'b0; ext_i = 1'b0;
    step_to(11);
    count_cycles(1, a, p);
    chk(a == 2, "R10", "ale count after mid-cycle glitch", a, 2);
    chk(p == 0, "R10", "psen count after mid-cycle glitch", p, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule